// File: doc/BRIEF.md
# Packed-Float to Integer Truncating Converter

This block turns a 32-bit packed floating-point operand into a 16-bit signed integer. The operand arrives split across two 16-bit register words. The high word `a_in` holds the upper fraction bits. The low word `b_in` holds the lower fraction byte, the exponent magnitude and the exponent sign. The result returns in the same pair of registers: the integer goes to `a_out` and a side value goes to `b_out`.

The contents of the side register are part of the contract and depend on the case:
- For a negative exponent, B keeps its incoming word.
- On overflow, B takes the incoming high word.
- In every other case, B takes the aligned integer before the toward-zero correction.

`ovf` reports a magnitude that does not fit. One pulse on `start` runs one conversion. The results appear with a one-cycle `done` pulse. A new `start` may arrive on every cycle, and the outputs hold between results.

Top module: `fix_conv`

## Requirements
- R1: The exponent is taken from `b_in[7:1]` as a magnitude, and `b_in[0]`=1 marks it negative. The decoded value is the two's-complement byte {b_in[0], b_in[7:1]}, in the range -128..127. The fraction is {a_in, b_in[15:8], 8'h00} read as a signed 32-bit value.
- R2: For a negative exponent, the result is `a_out`=0, `b_out`=incoming `b_in` and `ovf`=0.
- R3: For an exponent above 15, the result is `a_out`=16'h7FFF (octal 077777), `b_out`=incoming `a_in` and `ovf`=1. `ovf`=1 occurs in no other case.
- R4: For an exponent from 0 to 14, the fraction is shifted arithmetically right by (15 - exponent), with sign fill. Bits 31..16 of the shifted value form the pre-correction integer.
- R5: For an exponent of exactly 15, the pre-correction integer is the incoming `a_in`, and the shifted value counts as zero.
- R6: For exponents 0..15, `b_out` equals the pre-correction integer and `ovf`=0.
- R7: For exponents 0..15, `a_out` is the pre-correction integer plus 1 (modulo 2^16) when two conditions both hold. First, that integer is negative (bit 15 set). Second, the low 16 bits of the unshifted fraction or of the shifted value are nonzero. Otherwise `a_out` equals the pre-correction integer.
- R8: When `start` is sampled high at clock edge k, `done` is high for exactly the cycle after edge k+2. The results of that operation appear at the same time. Starts on consecutive cycles give `done` on consecutive cycles.
- R9: A synchronous active-high `rst` clears `a_out`, `b_out`, `ovf` and `done` to 0.
- R10: While `done` is low, `a_out`, `b_out` and `ovf` hold their values, whatever `a_in` and `b_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one conversion; operand words sampled at this edge |
| a_in | input | 16 | High operand word (sign and upper fraction) |
| b_in | input | 16 | Low operand word (low fraction byte, exponent, exponent sign) |
| a_out | output | 16 | Integer result register |
| b_out | output | 16 | Side-value register |
| ovf | output | 1 | Overflow flag of the last result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The conversion is a three-register pipeline. The operand words are captured at edge k, and the decoded and aligned values are registered at edge k+1. The final A, B and flag are registered at edge k+2, so every result is due in the cycle after edge k+2. The bench drives inputs on falling edges. It checks that `done` is still low one falling edge after the capturing edge, then checks `done` and all results on the next falling edge. A back-to-back pair checks results on two consecutive falling edges. A hold check changes the operand inputs with no start and samples two falling edges later.

// File: rtl/fix_pkg.sv
package fix_pkg;

  typedef enum logic [1:0] {
    FIX_UNDER = 2'd0,
    FIX_OVER  = 2'd1,
    FIX_EXACT = 2'd2,
    FIX_SHIFT = 2'd3
  } fix_class_e;

endpackage

// File: rtl/fix_unpack.sv
module fix_unpack
  import fix_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXP_W  = 7
) (
  input  logic [WORD_W-1:0]   a_op,
  input  logic [WORD_W-1:0]   b_op,
  output logic [2*WORD_W-1:0] frac,
  output fix_class_e          cls,
  output logic [$clog2(WORD_W)-1:0] shamt
);
  localparam int DW   = 2 * WORD_W;
  localparam int EW   = EXP_W + 1;
  localparam int SH_W = $clog2(WORD_W);
  localparam logic signed [EW-1:0] EXP_TOP = EW'(WORD_W - 1);

  logic signed [EW-1:0] exp_s;

  always_comb begin
    frac  = {a_op, b_op[WORD_W-1:EW], {EW{1'b0}}};
    exp_s = {b_op[0], b_op[EXP_W:1]};
    if (exp_s < 0)
      cls = FIX_UNDER;
    else if (exp_s > EXP_TOP)
      cls = FIX_OVER;
    else if (exp_s == EXP_TOP)
      cls = FIX_EXACT;
    else
      cls = FIX_SHIFT;
    shamt = SH_W'(EXP_TOP - exp_s);
  end

  initial begin
    if (DW - EW < WORD_W) $error("fraction narrower than a word");
  end

endmodule

// File: rtl/fix_align.sv
module fix_align #(
  parameter int WORD_W = 16
) (
  input  logic [2*WORD_W-1:0]       frac,
  input  logic [$clog2(WORD_W)-1:0] shamt,
  input  logic                      exact,
  input  logic [WORD_W-1:0]         a_op,
  output logic [WORD_W-1:0]         pre,
  output logic                      lost
);
  localparam int DW   = 2 * WORD_W;
  localparam int SH_W = $clog2(WORD_W);

  logic [DW-1:0] stg [0:SH_W];
  logic [DW-1:0] shifted;

  assign stg[0] = frac;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    assign stg[i+1] = shamt[i] ? DW'($signed(stg[i]) >>> (2 ** i)) : stg[i];
  end

  always_comb begin
    shifted = exact ? '0 : stg[SH_W];
    pre     = exact ? a_op : shifted[DW-1:WORD_W];
    lost    = |(frac[WORD_W-1:0] | shifted[WORD_W-1:0]);
  end

endmodule

// File: rtl/fix_correct.sv
module fix_correct
  import fix_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  fix_class_e        cls,
  input  logic [WORD_W-1:0] a_op,
  input  logic [WORD_W-1:0] b_op,
  input  logic [WORD_W-1:0] pre,
  input  logic              lost,
  output logic [WORD_W-1:0] a_res,
  output logic [WORD_W-1:0] b_res,
  output logic              ovf_res
);
  localparam logic [WORD_W-1:0] SAT = {1'b0, {(WORD_W-1){1'b1}}};

  always_comb begin
    case (cls)
      FIX_UNDER: begin
        a_res   = '0;
        b_res   = b_op;
        ovf_res = 1'b0;
      end
      FIX_OVER: begin
        a_res   = SAT;
        b_res   = a_op;
        ovf_res = 1'b1;
      end
      default: begin
        b_res   = pre;
        a_res   = (pre[WORD_W-1] && lost) ? pre + 1'b1 : pre;
        ovf_res = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fix_conv.sv
module fix_conv
  import fix_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXP_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] b_in,
  output logic [WORD_W-1:0] a_out,
  output logic [WORD_W-1:0] b_out,
  output logic              ovf,
  output logic              done
);
  localparam int DW   = 2 * WORD_W;
  localparam int SH_W = $clog2(WORD_W);

  // stage 0: captured operand
  logic              v0;
  logic [WORD_W-1:0] a0, b0;

  // decode of stage 0
  logic [DW-1:0]     frac0;
  fix_class_e        cls0;
  logic [SH_W-1:0]   sh0;
  logic [WORD_W-1:0] pre0;
  logic              lost0;

  // stage 1: decoded and aligned
  logic              v1;
  fix_class_e        cls1;
  logic [WORD_W-1:0] a1, b1, pre1;
  logic              lost1;

  // final selection
  logic [WORD_W-1:0] a_res, b_res;
  logic              ovf_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0;
      a0 <= '0;
      b0 <= '0;
    end else begin
      v0 <= start;
      if (start) begin
        a0 <= a_in;
        b0 <= b_in;
      end
    end
  end

  fix_unpack #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_unpack (
    .a_op  (a0),
    .b_op  (b0),
    .frac  (frac0),
    .cls   (cls0),
    .shamt (sh0)
  );

  fix_align #(.WORD_W(WORD_W)) u_align (
    .frac  (frac0),
    .shamt (sh0),
    .exact (cls0 == FIX_EXACT),
    .a_op  (a0),
    .pre   (pre0),
    .lost  (lost0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      cls1  <= FIX_UNDER;
      a1    <= '0;
      b1    <= '0;
      pre1  <= '0;
      lost1 <= 1'b0;
    end else begin
      v1 <= v0;
      if (v0) begin
        cls1  <= cls0;
        a1    <= a0;
        b1    <= b0;
        pre1  <= pre0;
        lost1 <= lost0;
      end
    end
  end

  fix_correct #(.WORD_W(WORD_W)) u_correct (
    .cls     (cls1),
    .a_op    (a1),
    .b_op    (b1),
    .pre     (pre1),
    .lost    (lost1),
    .a_res   (a_res),
    .b_res   (b_res),
    .ovf_res (ovf_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      b_out <= '0;
      ovf   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= v1;
      if (v1) begin
        a_out <= a_res;
        b_out <= b_res;
        ovf   <= ovf_res;
      end
    end
  end

endmodule

// File: rtl/fix_conv_chk.sv
module fix_conv_chk #(
  parameter int WORD_W = 16,
  parameter int EXP_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [WORD_W-1:0] a_in,
  input logic [WORD_W-1:0] b_in,
  input logic [WORD_W-1:0] a_out,
  input logic [WORD_W-1:0] b_out,
  input logic              ovf,
  input logic              done
);
  localparam logic [WORD_W-1:0] SAT = {1'b0, {(WORD_W-1){1'b1}}};

  logic              s0, s1;
  logic [WORD_W-1:0] ca0, ca1, ca2, cb0, cb1, cb2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0 <= 1'b0; s1 <= 1'b0;
      ca0 <= '0; ca1 <= '0; ca2 <= '0;
      cb0 <= '0; cb1 <= '0; cb2 <= '0;
    end else begin
      s0 <= start; s1 <= s0;
      ca0 <= a_in; ca1 <= ca0; ca2 <= ca1;
      cb0 <= b_in; cb1 <= cb0; cb2 <= cb1;
    end
  end

  AST_DONE_DUE:    assert property (@(posedge clk) disable iff (rst) s1 |=> done);   // R8
  AST_DONE_ONLY:   assert property (@(posedge clk) disable iff (rst) !s1 |=> !done); // R8
  AST_OVF_SAT:     assert property (@(posedge clk) disable iff (rst) ovf |-> a_out == SAT); // R3
  AST_OVF_B:       assert property (@(posedge clk) disable iff (rst)
                     (done && ovf) |-> b_out == ca2); // R3
  AST_UNDER:       assert property (@(posedge clk) disable iff (rst)
                     (done && cb2[0]) |-> (a_out == '0 && b_out == cb2 && !ovf)); // R2
  AST_HOLD:        assert property (@(posedge clk) disable iff (rst)
                     !done |-> ($stable(a_out) && $stable(b_out) && $stable(ovf))); // R10

endmodule

bind fix_conv fix_conv_chk #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/sim_fix_conv.sv
module sim_fix_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic        ovf, done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fix_conv u0 (.clk, .rst, .start, .a_in, .b_in, .a_out, .b_out, .ovf, .done);

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic model(input logic [15:0] a, input logic [15:0] b,
                       output logic [15:0] ea, output logic [15:0] eb, output logic eo,
                       output string tag);
    int e;
    int fr;
    int sh;
    logic [15:0] pre;
    bit lost;
    e  = b[0] ? int'(b[7:1]) - 128 : int'(b[7:1]);
    fr = int'({a, b[15:8], 8'h00});
    if (e < 0) begin
      ea = 16'h0000; eb = b; eo = 1'b0; tag = "R1 R2";
    end else if (e > 15) begin
      ea = 16'h7FFF; eb = a; eo = 1'b1; tag = "R1 R3";
    end else begin
      if (e == 15) begin
        sh = 0; pre = a; tag = "R1 R5 R6 R7";
      end else begin
        sh = fr >>> (15 - e); pre = sh[31:16]; tag = "R1 R4 R6 R7";
      end
      lost = ((fr & 32'hFFFF) != 0) || ((sh & 32'hFFFF) != 0);
      eb = pre; eo = 1'b0;
      ea = (pre[15] && lost) ? pre + 16'd1 : pre;
    end
  endtask

  task automatic run_one(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] ea, eb;
    logic eo;
    string tag;
    model(a, b, ea, eb, eo, tag);
    @(negedge clk); start = 1'b1; a_in = a; b_in = b;
    @(negedge clk); start = 1'b0; a_in = ~a; b_in = ~b;
    @(negedge clk);
    chk(done == 1'b0, "R8 done early", {47'd0, done}, 48'd0);
    @(negedge clk);
    chk(done == 1'b1, "R8 done due", {47'd0, done}, 48'd1);
    chk({a_out, b_out, ovf} == {ea, eb, eo}, tag,
        {15'd0, a_out, b_out, ovf}, {15'd0, ea, eb, eo});
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", {47'd0, done}, 48'd0);
  endtask

  localparam logic [15:0] A_PAT [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                        16'hFFFF, 16'h1234, 16'hC001, 16'h8001};
  localparam logic [7:0]  BH_PAT [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] ea, eb, ha, hb;
    logic eo, ho;
    string tag;
    repeat (3) @(negedge clk);
    chk({a_out, b_out, ovf, done} == 34'd0, "R9 reset",
        {14'd0, a_out, b_out, ovf, done}, 48'd0);
    rst = 1'b0;

    // corner exponents for R1: -128, +127, 15
    run_one(16'h4000, 16'h0001);
    run_one(16'h4000, 16'h00FE);
    run_one(16'hC000, 16'h801E);

    for (int ai = 0; ai < 8; ai++)
      for (int bi = 0; bi < 4; bi++)
        for (int ex = 0; ex < 256; ex++)
          run_one(A_PAT[ai], {BH_PAT[bi], 8'(ex)});

    // R8 back-to-back starts
    model(16'h8001, 16'h8016, ea, eb, eo, tag);
    model(16'h1234, 16'h00FC, ha, hb, ho, tag);
    @(negedge clk); start = 1'b1; a_in = 16'h8001; b_in = 16'h8016;
    @(negedge clk); a_in = 16'h1234; b_in = 16'h00FC;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(done && {a_out, b_out, ovf} == {ea, eb, eo}, "R8 first of pair",
        {14'd0, done, a_out, b_out, ovf}, {14'd0, 1'b1, ea, eb, eo});
    @(negedge clk);
    chk(done && {a_out, b_out, ovf} == {ha, hb, ho}, "R8 second of pair",
        {14'd0, done, a_out, b_out, ovf}, {14'd0, 1'b1, ha, hb, ho});

    // R10 hold with changing inputs and no start
    @(negedge clk); a_in = 16'h5555; b_in = 16'h0010;
    @(negedge clk); a_in = 16'hAAAA; b_in = 16'h0003;
    @(negedge clk);
    chk(!done && {a_out, b_out, ovf} == {ha, hb, ho}, "R10 hold",
        {14'd0, done, a_out, b_out, ovf}, {14'd0, 1'b0, ha, hb, ho});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule